// File: doc/BRIEF.md
# Three-Wire Variable-Length Control Receiver

This block is a serial slave for a tuning synthesizer. It takes control words over three wires: an enable, a serial clock and a data line. It loads them into three registers: a four-bit band-switch register, a 15-bit divider register and a control register. The control register holds the charge-pump current select, three test-mode bits, two reference-ratio select bits and a tuning-output disable bit.

The number of bits that arrive while the enable is high picks what is loaded and when.

- **18 or 19 bits:** the divider is written when the enable falls.
- **27 bits:** the divider is written on the 20th rising serial clock edge and the control fields when the enable falls.
- **20 to 26 bits:** only the divider is written.
- **Fewer than 18 bits:** the divider is left alone.

The band bits are always written as soon as a fifth rising clock edge arrives. All three serial wires are resynchronised into the system clock. Every output changes only on a system clock edge. An asynchronous power-on reset input restores the power-on defaults.

Top module: `tw_ctrl_rx`

## Requirements
- R1: Serial data is sampled on the falling edge of the serial clock, most significant bit first. The frame bit order is: band bits B3..B0 (frame bits 1-4), divider N14..N0 (bits 5-19), then CP, T2, T1, T0, RA, RB, OD and one spare bit (bits 20-27).
- R2: Band bits 1-4 are copied to `band_en` (bit 1 to `band_en[3]`) on the fifth rising serial clock edge of a frame, while the enable is still high.
- R3: An 18-bit frame, on the enable's falling edge, loads `div_word` with 0 in bit 14 and frame bits 5-18 in bits 13..0, and sets `ratio_a` to 1.
- R4: A 19-bit frame, on the enable's falling edge, loads `div_word` from frame bits 5-19 and clears `ratio_a`.
- R5: A 27-bit frame loads `div_word` on the 20th rising serial clock edge, before the enable falls. On the enable's falling edge it loads `cp_hi`, `test_mode`, `ratio_a`, `ratio_b` and `tune_off` from frame bits 20, 21-23, 24, 25 and 26.
- R6: `cp_hi`, `test_mode`, `ratio_b` and `tune_off` change only at the end of a 27-bit frame. 18-bit and 19-bit frames leave them as they were.
- R7: A frame of fewer than 18 bits leaves `div_word` and `ratio_a` unchanged.
- R8: A frame of 20 to 26 bits loads `div_word` at the 20th rising edge and leaves all control fields unchanged.
- R9: Bits after the 27th in a frame are ignored. Such a frame acts as a 27-bit frame built from its first 27 bits.
- R10: While `por_n` is low, the outputs are held at their defaults: `band_en`=0, `div_word`=0, `cp_hi`=1, `test_mode`=3'b001, `ratio_a`=1, `ratio_b`=parameter `RB_INIT`, `tune_off`=1.
- R11: Serial clock edges while the enable is low change no output and do not count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ser_en | input | 1 | Serial frame enable, high during a frame |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| band_en | output | 4 | Band-switch enables |
| div_word | output | 15 | Programmable divider word |
| cp_hi | output | 1 | Charge-pump high-current select |
| test_mode | output | 3 | Test-mode bits (001 = normal) |
| ratio_a | output | 1 | Reference ratio select A |
| ratio_b | output | 1 | Reference ratio select B |
| tune_off | output | 1 | Tuning output disable |

## Verification
Directed frames of 4, 10, 18, 19, 23, 27 and 30 bits cover every branch of the length decode. An 18-bit frame sent right after a 19-bit frame shows whether the forced zero in divider bit 14 and the `ratio_a` toggle come from the length alone. Checks in the middle of a frame, after the fourth and fifth bits and after the 19th and 20th bits, tell a commit on a clock edge from a commit at the end of the frame. Random lengths and data then exercise bit ordering and field placement. Clock pulses while the enable is low, and a power-on reset in the middle of the run, show that stray edges are ignored and that the defaults return.

// File: rtl/tw_ctrl_pkg.sv
`timescale 1ns/1ps
package tw_ctrl_pkg;
  localparam int BAND_W    = 4;
  localparam int DIV_W     = 15;
  localparam int CTRL_W    = 8;
  localparam int LEN_SHORT = BAND_W + DIV_W - 1;   // 18
  localparam int LEN_MID   = BAND_W + DIV_W;       // 19
  localparam int LEN_LONG  = LEN_MID + CTRL_W;     // 27
  localparam int CNT_W     = $clog2(LEN_LONG + 1);

  typedef struct packed {
    logic       cp_hi;
    logic [2:0] test;
    logic       ra;
    logic       rb;
    logic       off;
  } ctrl_t;

  // Tail of a long frame: CP, T2, T1, T0, RA, RB, OD, spare
  function automatic ctrl_t ctrl_from_tail(input logic [CTRL_W-1:0] t);
    ctrl_t c;
    c.cp_hi = t[7];
    c.test  = t[6:4];
    c.ra    = t[3];
    c.rb    = t[2];
    c.off   = t[1];
    return c;
  endfunction

  // Short frame carries one divider bit fewer; the top bit is forced low
  function automatic logic [DIV_W-1:0] div_from_short(input logic [DIV_W-2:0] x);
    return {1'b0, x};
  endfunction
endpackage

// File: rtl/tw_sync.sv
`timescale 1ns/1ps
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_frame_rx.sv
`timescale 1ns/1ps
module tw_frame_rx
  import tw_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                por_n,
  input  logic                en_s,
  input  logic                sck_s,
  input  logic                sd_s,
  output logic [LEN_LONG-1:0] sh,
  output logic [CNT_W-1:0]    cnt,
  output logic                ev_sample,
  output logic                ev_band_ld,
  output logic                ev_freq_edge,
  output logic                ev_end_short,
  output logic                ev_end_mid,
  output logic                ev_end_long
);
  logic en_q, sck_q;
  logic sck_rise, sck_fall, en_fall;

  assign sck_rise = en_s & sck_s & ~sck_q;
  assign sck_fall = en_s & ~sck_s & sck_q;
  assign en_fall  = en_q & ~en_s;

  assign ev_sample    = sck_fall && (cnt < CNT_W'(LEN_LONG));
  assign ev_band_ld   = sck_rise && (cnt == CNT_W'(BAND_W));
  assign ev_freq_edge = sck_rise && (cnt == CNT_W'(LEN_MID));
  assign ev_end_short = en_fall && (cnt == CNT_W'(LEN_SHORT));
  assign ev_end_mid   = en_fall && (cnt == CNT_W'(LEN_MID));
  assign ev_end_long  = en_fall && (cnt == CNT_W'(LEN_LONG));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      sck_q <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
    end else begin
      en_q  <= en_s;
      sck_q <= sck_s;
      if (!en_s) begin
        cnt <= '0;
      end else if (ev_sample) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[LEN_LONG-2:0], sd_s};
      end
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
`timescale 1ns/1ps
module tw_reg_bank
  import tw_ctrl_pkg::*;
#(
  parameter logic RB_INIT = 1'b0
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic [LEN_LONG-1:0] sh,
  input  logic                ev_band_ld,
  input  logic                ev_freq_edge,
  input  logic                ev_end_short,
  input  logic                ev_end_mid,
  input  logic                ev_end_long,
  output logic [BAND_W-1:0]   band,
  output logic [DIV_W-1:0]    div,
  output ctrl_t               ctrl
);
  localparam ctrl_t CTRL_INIT = '{cp_hi: 1'b1, test: 3'b001, ra: 1'b1, rb: RB_INIT, off: 1'b1};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      band <= '0;
      div  <= '0;
      ctrl <= CTRL_INIT;
    end else begin
      if (ev_band_ld) band <= sh[BAND_W-1:0];
      if (ev_freq_edge || ev_end_mid) div <= sh[DIV_W-1:0];
      if (ev_end_short) begin
        div     <= div_from_short(sh[DIV_W-2:0]);
        ctrl.ra <= 1'b1;
      end
      if (ev_end_mid)  ctrl.ra <= 1'b0;
      if (ev_end_long) ctrl    <= ctrl_from_tail(sh[CTRL_W-1:0]);
    end
  end
endmodule

// File: rtl/tw_ctrl_rx.sv
`timescale 1ns/1ps
module tw_ctrl_rx
  import tw_ctrl_pkg::*;
#(
  parameter logic RB_INIT     = 1'b0,
  parameter int   SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        ser_en,
  input  logic        ser_clk,
  input  logic        ser_dat,
  output logic [3:0]  band_en,
  output logic [14:0] div_word,
  output logic        cp_hi,
  output logic [2:0]  test_mode,
  output logic        ratio_a,
  output logic        ratio_b,
  output logic        tune_off
);
  logic [2:0]          sync_q;
  logic [LEN_LONG-1:0] frm_sh;
  logic [CNT_W-1:0]    frm_cnt;
  logic ev_sample, ev_band_ld, ev_freq_edge, ev_end_short, ev_end_mid, ev_end_long;
  ctrl_t ctrl;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n),
    .d({ser_en, ser_clk, ser_dat}),
    .q(sync_q)
  );

  tw_frame_rx u_frame (
    .clk(clk), .por_n(por_n),
    .en_s(sync_q[2]), .sck_s(sync_q[1]), .sd_s(sync_q[0]),
    .sh(frm_sh), .cnt(frm_cnt),
    .ev_sample(ev_sample), .ev_band_ld(ev_band_ld), .ev_freq_edge(ev_freq_edge),
    .ev_end_short(ev_end_short), .ev_end_mid(ev_end_mid), .ev_end_long(ev_end_long)
  );

  tw_reg_bank #(.RB_INIT(RB_INIT)) u_regs (
    .clk(clk), .por_n(por_n), .sh(frm_sh),
    .ev_band_ld(ev_band_ld), .ev_freq_edge(ev_freq_edge),
    .ev_end_short(ev_end_short), .ev_end_mid(ev_end_mid), .ev_end_long(ev_end_long),
    .band(band_en), .div(div_word), .ctrl(ctrl)
  );

  assign cp_hi     = ctrl.cp_hi;
  assign test_mode = ctrl.test;
  assign ratio_a   = ctrl.ra;
  assign ratio_b   = ctrl.rb;
  assign tune_off  = ctrl.off;
endmodule

// File: rtl/tw_ctrl_rx_chk.sv
`timescale 1ns/1ps
module tw_ctrl_rx_chk
  import tw_ctrl_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic [3:0]       band_en,
  input logic [14:0]      div_word,
  input logic             cp_hi,
  input logic [2:0]       test_mode,
  input logic             ratio_a,
  input logic             ratio_b,
  input logic             tune_off,
  input logic [CNT_W-1:0] cnt,
  input logic             ev_sample,
  input logic             ev_band_ld,
  input logic             ev_freq_edge,
  input logic             ev_end_short,
  input logic             ev_end_mid,
  input logic             ev_end_long
);
  AST_BAND_ONLY_ON_EDGE5: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(band_en) |-> $past(ev_band_ld));                                  // R2
  AST_DIV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(div_word) |-> $past(ev_freq_edge || ev_end_short || ev_end_mid)); // R7
  AST_SHORT_MSB_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    ev_end_short |=> (div_word[14] == 1'b0) && ratio_a);                       // R3
  AST_MID_RA_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    ev_end_mid |=> !ratio_a);                                                  // R4
  AST_CTRL_LONG_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    !$stable({cp_hi, test_mode, ratio_b, tune_off}) |-> $past(ev_end_long));   // R6
  AST_RA_SOURCE: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(ratio_a) |-> $past(ev_end_short || ev_end_mid || ev_end_long));   // R8
  AST_END_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({ev_end_short, ev_end_mid, ev_end_long}));                        // R1
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (!por_n)
    (cnt <= CNT_W'(LEN_LONG)) && !(ev_sample && cnt == CNT_W'(LEN_LONG)));     // R9
endmodule

bind tw_ctrl_rx tw_ctrl_rx_chk u_chk (
  .clk(clk), .por_n(por_n), .band_en(band_en), .div_word(div_word),
  .cp_hi(cp_hi), .test_mode(test_mode), .ratio_a(ratio_a), .ratio_b(ratio_b),
  .tune_off(tune_off), .cnt(frm_cnt), .ev_sample(ev_sample),
  .ev_band_ld(ev_band_ld), .ev_freq_edge(ev_freq_edge),
  .ev_end_short(ev_end_short), .ev_end_mid(ev_end_mid), .ev_end_long(ev_end_long)
);

// File: tb/tw_ctrl_rx_tb.sv
`timescale 1ns/1ps
module tw_ctrl_rx_tb;
  localparam logic RB_INIT = 1'b0;
  localparam int   PH = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [3:0]  band_en;
  logic [14:0] div_word;
  logic cp_hi, ratio_a, ratio_b, tune_off;
  logic [2:0] test_mode;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [3:0]  m_band;
  logic [14:0] m_div;
  logic        m_cp, m_ra, m_rb, m_off;
  logic [2:0]  m_t;

  always #4 clk = ~clk;

  tw_ctrl_rx #(.RB_INIT(RB_INIT)) u_dut (
    .clk(clk), .por_n(por_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .band_en(band_en), .div_word(div_word), .cp_hi(cp_hi), .test_mode(test_mode),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .tune_off(tune_off)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic model_reset();
    m_band = '0; m_div = '0; m_cp = 1'b1; m_t = 3'b001; m_ra = 1'b1; m_rb = RB_INIT; m_off = 1'b1;
  endtask

  // Expected state after a frame of n bits; fb[k] is frame bit k, first sent is k=1
  task automatic model_frame(input int n, input logic [30:1] fb);
    int e;
    e = (n > 27) ? 27 : n;
    if (e >= 5) m_band = {fb[1], fb[2], fb[3], fb[4]};
    if (e >= 19) for (int i = 0; i < 15; i++) m_div[14-i] = fb[5+i];
    if (e == 18) begin
      m_div[14] = 1'b0;
      for (int i = 0; i < 14; i++) m_div[13-i] = fb[5+i];
      m_ra = 1'b1;
    end
    if (e == 19) m_ra = 1'b0;
    if (e == 27) begin
      m_cp = fb[20]; m_t = {fb[21], fb[22], fb[23]};
      m_ra = fb[24]; m_rb = fb[25]; m_off = fb[26];
    end
  endtask

  task automatic check_all(input string req);
    chk(band_en == m_band, {req, " band_en"}, 32'(band_en), 32'(m_band));
    chk(div_word == m_div, {req, " div_word"}, 32'(div_word), 32'(m_div));
    chk({cp_hi, test_mode, ratio_a, ratio_b, tune_off} == {m_cp, m_t, m_ra, m_rb, m_off},
        {req, " ctrl"}, 32'({cp_hi, test_mode, ratio_a, ratio_b, tune_off}),
        32'({m_cp, m_t, m_ra, m_rb, m_off}));
  endtask

  task automatic fr_begin();
    ser_clk = 1'b0; ser_en = 1'b1; waitc(PH);
  endtask
  task automatic fr_bit(input logic b);
    ser_dat = b; waitc(PH);
    ser_clk = 1'b1; waitc(PH);
    ser_clk = 1'b0; waitc(PH);
  endtask
  task automatic fr_end();
    ser_en = 1'b0; waitc(2 * PH);
  endtask
  task automatic send(input int n, input logic [30:1] fb);
    fr_begin();
    for (int k = 1; k <= n; k++) fr_bit(fb[k]);
    fr_end();
    model_frame(n, fb);
  endtask

  function automatic logic [30:1] rand_fb();
    return 30'($urandom());
  endfunction

  initial begin
    logic [30:1] fb;
    logic [3:0]  b_before;
    logic [14:0] d_before;
    void'($urandom(32'h1A2B3C));
    model_reset();
    waitc(3);
    chk(div_word == 15'd0, "R10 div held in reset", 32'(div_word), 0);
    por_n = 1'b1; waitc(4);
    check_all("R10 defaults");

    // R11: clocks with enable low
    for (int i = 0; i < 10; i++) begin ser_dat = i[0]; ser_clk = 1'b1; waitc(PH); ser_clk = 1'b0; waitc(PH); end
    check_all("R11 stray clocks");
    fb = rand_fb(); send(18, fb);
    check_all("R11 count not advanced by stray clocks / R3 18-bit");

    fb = '1; send(19, fb); check_all("R4 19-bit");
    fb = '1; send(18, fb); check_all("R3 msb forced zero");

    // R2 and R5: mid-frame commits in a 27-bit frame
    fb = rand_fb(); fb[1:4] = ~m_band;
    fr_begin();
    for (int k = 1; k <= 4; k++) fr_bit(fb[k]);
    chk(band_en == m_band, "R2 band held after 4 bits", 32'(band_en), 32'(m_band));
    fr_bit(fb[5]);
    chk(band_en == {fb[1], fb[2], fb[3], fb[4]}, "R2 band after 5th edge", 32'(band_en), 32'({fb[1], fb[2], fb[3], fb[4]}));
    for (int k = 6; k <= 19; k++) fr_bit(fb[k]);
    d_before = div_word;
    chk(d_before == m_div, "R5 div held after 19 bits", 32'(d_before), 32'(m_div));
    fr_bit(fb[20]);
    b_before = band_en;
    model_frame(27, fb);
    chk(div_word == m_div, "R5 div at 20th edge", 32'(div_word), 32'(m_div));
    for (int k = 21; k <= 27; k++) fr_bit(fb[k]);
    fr_end();
    check_all("R5 27-bit end");
    chk(b_before == m_band, "R2 band stable", 32'(b_before), 32'(m_band));

    fb = rand_fb(); fb[20:26] = 7'b1001011;
    send(27, fb); check_all("R5 control load");
    fb = rand_fb(); send(18, fb); check_all("R6 control kept over 18-bit");
    fb = rand_fb(); send(19, fb); check_all("R6 control kept over 19-bit");
    fb = rand_fb(); send(10, fb); check_all("R7 short frame");
    fb = rand_fb(); send(17, fb); check_all("R7 17-bit frame");
    fb = rand_fb(); send(4, fb);  check_all("R7 4-bit frame");
    fb = rand_fb(); send(23, fb); check_all("R8 23-bit frame");
    fb = rand_fb(); send(20, fb); check_all("R8 20-bit frame");
    fb = rand_fb(); send(30, fb); check_all("R9 30-bit frame");

    for (int i = 0; i < 60; i++) begin
      int n;
      case ($urandom_range(0, 5))
        0: n = 18; 1: n = 19; 2: n = 27;
        default: n = $urandom_range(1, 30);
      endcase
      fb = rand_fb(); send(n, fb);
      check_all($sformatf("R1 random len %0d", n));
    end

    por_n = 1'b0; waitc(2); model_reset();
    check_all("R10 reset mid-run");
    por_n = 1'b1; waitc(4);
    check_all("R10 after release");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    waitc(150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule